// File: doc/BRIEF.md
# Packet Fragment Sequence Error Checker

This block sits in front of a crypto packet engine and inspects each fragment command as it is accepted. A packet reaches the engine as one or more fragments. The first fragment carries the start flag and the final one carries the last flag. The first fragment also supplies the total packet length in words and the cipher settings. The checker keeps track of whether a packet is open and adds up the source words of its fragments. It compares that running sum, the flags, the cipher region length and the destination counts that were actually written against the framing rules.

Each rule violation sets a sticky bit in a 10-bit error field. Nothing except a software reset or the hardware reset clears these bits. One cycle after each fragment, the block presents a 32-bit result word. The error field sits at bits 16 to 25 of that word, next to a packet-end flag and a current-end-by-count flag. An interrupt line is raised whenever an error bit is set and its enable bit is also set.

Top module: `frag_seq_checker`

## Requirements
- R1: Error field bit 0 (result bit 16) is set when a fragment carries the last flag but the source words summed since the start fragment are below the packet total.
- R2: Error field bit 1 (result bit 17) is set when the summed source words reach or exceed the packet total on a fragment that does not carry the last flag.
- R3: Error field bit 2 (result bit 18) is set when a last fragment arrives while the encrypt-to-MAC path still reports pending data.
- R4: Error field bit 3 (result bit 19) is set when, on a last fragment, the destination MAC word count written differs from its programmed length. Error field bit 4 (result bit 20) is set when, on any fragment, the destination encrypt word count differs from its programmed length.
- R5: On a start fragment, error field bit 5 (result bit 21) is set when the encryption region length is zero. Error field bit 6 (result bit 22) is set when either the encrypt enable or the MAC enable is low.
- R6: Error field bit 7 (result bit 23) is set when a start fragment arrives while a packet is open. Error field bit 8 (result bit 24) is set when a non-start fragment arrives while no packet is open.
- R7: Error field bit 9 (result bit 25) is set on a start fragment with encryption enabled when the encryption length is not a multiple of 2 words for algorithm codes 0 (DES) and 1 (3DES), or not a multiple of 4 words for codes 2 (SEED) and 3 (AES).
- R8: Error bits are sticky. Once set, a bit stays set through later fragments until the software reset is pulsed. The cycle after that pulse, all error bits, the open-packet state and the result strobe are clear. A software reset takes priority over a fragment presented in the same cycle.
- R9: The interrupt output is high exactly when some error field bit and its matching enable bit (enable bit i gates error bit i) are both 1.
- R10: The cycle after an accepted fragment, the result strobe is high and the result word holds the last flag in bit 0, the flag "summed words have reached the total" in bit 1, the updated error field in bits 25:16, and zeros elsewhere. The strobe is low in every other cycle.
- R11: A fragment that carries both the start and last flags forms a complete packet, and the busy output is low the cycle after it. A start fragment without the last flag makes busy high. The packet total is taken from the start fragment only.
- R12: After the hardware reset, busy, the error field, the interrupt and the result strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swReset | input | 1 | Synchronous software reset, clears errors and packet state |
| fragValid | input | 1 | A fragment command is presented this cycle |
| fragStart | input | 1 | Fragment opens a packet |
| fragLast | input | 1 | Fragment closes a packet |
| encEn | input | 1 | Encryption enabled for the packet |
| macEn | input | 1 | MAC enabled for the packet |
| cipherAlg | input | 2 | 0 DES, 1 3DES, 2 SEED, 3 AES |
| encLen | input | LEN_W | Encryption region length in words |
| srcWords | input | CNT_W | Source words carried by this fragment |
| totalWords | input | CNT_W | Total packet words (used from the start fragment) |
| dstEncWritten | input | ENC_DST_W | Destination encrypt words actually written |
| dstEncLen | input | ENC_DST_W | Programmed destination encrypt length |
| dstMacWritten | input | MAC_DST_W | Destination MAC words actually written |
| dstMacLen | input | MAC_DST_W | Programmed destination MAC length |
| encMacPending | input | 1 | Encrypt-to-MAC path still holds data |
| intEn | input | 10 | Per-bit interrupt enables for the error field |
| busy | output | 1 | A packet is open |
| errField | output | 10 | Sticky error bits |
| irq | output | 1 | Enabled error interrupt |
| resultValid | output | 1 | Result word strobe |
| resultWord | output | 32 | Per-fragment result word |

## Verification
The length errors in R1 and R2 are the hardest to provoke. They only appear after a packet has been split across several fragments, and the mismatch lies between a running sum and a total that was captured at the start fragment and is then ignored on later fragments. The bench therefore builds multi-fragment packets, both directed and random. On follow-up fragments it feeds a misleading total, and it places the last flag before, exactly at, or after the point where the sum reaches the total. Because the error bits are sticky, the random phase pulses the software reset often, so that each new error stays visible against a clean field.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int ERR_W   = 10;
  localparam int ERR_LSB = 16;
  localparam int RES_W   = 32;

  localparam int E_SHORT   = 0;
  localparam int E_NOLAST  = 1;
  localparam int E_PENDING = 2;
  localparam int E_MACCNT  = 3;
  localparam int E_ENCCNT  = 4;
  localparam int E_ENCZERO = 5;
  localparam int E_SECOFF  = 6;
  localparam int E_OVSTART = 7;
  localparam int E_ORPHAN  = 8;
  localparam int E_BLKWID  = 9;

  typedef enum logic [1:0] {
    ALG_DES  = 2'd0,
    ALG_TDES = 2'd1,
    ALG_SEED = 2'd2,
    ALG_AES  = 2'd3
  } cipherAlg_e;

  typedef struct packed {
    logic take;
    logic openPkt;
    logic continuePkt;
    logic overStart;
    logic orphan;
    logic clear;
  } seqStrobe_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       fragValid,
  input  logic       fragStart,
  input  logic       fragLast,
  output seqStrobe_t strobe,
  output logic       busy
);
  logic inPacket;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPacket <= 1'b0;
    end else if (swReset) begin
      inPacket <= 1'b0;
    end else if (fragValid) begin
      inPacket <= !fragLast && (fragStart || inPacket);
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.clear       = swReset;
    strobe.take        = fragValid && !swReset;
    strobe.openPkt     = strobe.take && fragStart;
    strobe.continuePkt = strobe.take && !fragStart && inPacket;
    strobe.overStart   = strobe.take && fragStart && inPacket;
    strobe.orphan      = strobe.take && !fragStart && !inPacket;
  end

  assign busy = inPacket;
endmodule

// File: rtl/fsc_blk_width.sv
module fsc_blk_width
  import fsc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [1:0]       cipherAlg,
  input  logic [LEN_W-1:0] encLen,
  output logic             misaligned
);
  localparam int NARROW_BITS = 1;
  localparam int WIDE_BITS   = 2;

  logic narrowBad;
  logic wideBad;

  assign narrowBad = |encLen[NARROW_BITS-1:0];
  assign wideBad   = |encLen[WIDE_BITS-1:0];

  always_comb begin
    case (cipherAlg_e'(cipherAlg))
      ALG_DES, ALG_TDES: misaligned = narrowBad;
      default:           misaligned = wideBad;
    endcase
  end
endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 16,
  parameter int ENC_DST_W = 9,
  parameter int MAC_DST_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic                 fragLast,
  input  logic                 encEn,
  input  logic                 macEn,
  input  logic [1:0]           cipherAlg,
  input  logic [LEN_W-1:0]     encLen,
  input  logic [CNT_W-1:0]     srcWords,
  input  logic [CNT_W-1:0]     totalWords,
  input  logic [ENC_DST_W-1:0] dstEncWritten,
  input  logic [ENC_DST_W-1:0] dstEncLen,
  input  logic [MAC_DST_W-1:0] dstMacWritten,
  input  logic [MAC_DST_W-1:0] dstMacLen,
  input  logic                 encMacPending,
  input  logic [ERR_W-1:0]     intEn,
  output logic [ERR_W-1:0]     errField,
  output logic                 irq,
  output logic                 resultValid,
  output logic [RES_W-1:0]     resultWord
);
  logic [CNT_W-1:0] accQ;
  logic [CNT_W-1:0] totalQ;
  logic [CNT_W-1:0] effTotal;
  logic [CNT_W-1:0] accBase;
  logic [CNT_W-1:0] accNext;
  logic             reached;
  logic             misaligned;
  logic [ERR_W-1:0] errQ;
  logic [ERR_W-1:0] newErr;
  logic [ERR_W-1:0] errNext;
  logic [RES_W-1:0] wordNext;
  logic             resValidQ;
  logic [RES_W-1:0] resWordQ;

  fsc_blk_width #(.LEN_W(LEN_W)) u_width (
    .cipherAlg (cipherAlg),
    .encLen    (encLen),
    .misaligned(misaligned)
  );

  always_comb begin
    effTotal = strobe.openPkt ? totalWords : totalQ;
    accBase  = strobe.openPkt ? '0 : accQ;
    accNext  = accBase + srcWords;
    reached  = (accNext >= effTotal);

    newErr            = '0;
    newErr[E_SHORT]   = fragLast && !reached;
    newErr[E_NOLAST]  = reached && !fragLast;
    newErr[E_PENDING] = fragLast && encMacPending;
    newErr[E_MACCNT]  = fragLast && (dstMacWritten != dstMacLen);
    newErr[E_ENCCNT]  = (dstEncWritten != dstEncLen);
    newErr[E_ENCZERO] = strobe.openPkt && (encLen == '0);
    newErr[E_SECOFF]  = strobe.openPkt && !(encEn && macEn);
    newErr[E_OVSTART] = strobe.overStart;
    newErr[E_ORPHAN]  = strobe.orphan;
    newErr[E_BLKWID]  = strobe.openPkt && encEn && misaligned;

    errNext = errQ | (strobe.take ? newErr : '0);

    wordNext                      = '0;
    wordNext[0]                   = fragLast;
    wordNext[1]                   = reached;
    wordNext[ERR_LSB +: ERR_W]    = errNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ      <= '0;
      accQ      <= '0;
      totalQ    <= '0;
      resValidQ <= 1'b0;
      resWordQ  <= '0;
    end else if (strobe.clear) begin
      errQ      <= '0;
      accQ      <= '0;
      totalQ    <= '0;
      resValidQ <= 1'b0;
      resWordQ  <= '0;
    end else begin
      resValidQ <= strobe.take;
      if (strobe.take) begin
        errQ     <= errNext;
        resWordQ <= wordNext;
        totalQ   <= effTotal;
        if (fragLast || strobe.orphan) begin
          accQ <= '0;
        end else if (strobe.openPkt || strobe.continuePkt) begin
          accQ <= accNext;
        end
      end
    end
  end

  assign errField    = errQ;
  assign irq         = |(errQ & intEn);
  assign resultValid = resValidQ;
  assign resultWord  = resWordQ;
endmodule

// File: rtl/frag_seq_checker.sv
module frag_seq_checker
  import fsc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 16,
  parameter int ENC_DST_W = 9,
  parameter int MAC_DST_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swReset,
  input  logic                 fragValid,
  input  logic                 fragStart,
  input  logic                 fragLast,
  input  logic                 encEn,
  input  logic                 macEn,
  input  logic [1:0]           cipherAlg,
  input  logic [LEN_W-1:0]     encLen,
  input  logic [CNT_W-1:0]     srcWords,
  input  logic [CNT_W-1:0]     totalWords,
  input  logic [ENC_DST_W-1:0] dstEncWritten,
  input  logic [ENC_DST_W-1:0] dstEncLen,
  input  logic [MAC_DST_W-1:0] dstMacWritten,
  input  logic [MAC_DST_W-1:0] dstMacLen,
  input  logic                 encMacPending,
  input  logic [9:0]           intEn,
  output logic                 busy,
  output logic [9:0]           errField,
  output logic                 irq,
  output logic                 resultValid,
  output logic [31:0]          resultWord
);
  seqStrobe_t strobe;

  fsc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .swReset  (swReset),
    .fragValid(fragValid),
    .fragStart(fragStart),
    .fragLast (fragLast),
    .strobe   (strobe),
    .busy     (busy)
  );

  fsc_datapath #(
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W),
    .ENC_DST_W(ENC_DST_W),
    .MAC_DST_W(MAC_DST_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fragLast     (fragLast),
    .encEn        (encEn),
    .macEn        (macEn),
    .cipherAlg    (cipherAlg),
    .encLen       (encLen),
    .srcWords     (srcWords),
    .totalWords   (totalWords),
    .dstEncWritten(dstEncWritten),
    .dstEncLen    (dstEncLen),
    .dstMacWritten(dstMacWritten),
    .dstMacLen    (dstMacLen),
    .encMacPending(encMacPending),
    .intEn        (intEn),
    .errField     (errField),
    .irq          (irq),
    .resultValid  (resultValid),
    .resultWord   (resultWord)
  );
endmodule

// File: rtl/fsc_sva.sv
module fsc_sva (
  input logic       clk,
  input logic       rstN,
  input logic       swReset,
  input logic       fragValid,
  input logic       fragStart,
  input logic       fragLast,
  input logic       busy,
  input logic [9:0] errField,
  input logic       resultValid
);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !swReset |=> ((errField & $past(errField)) == $past(errField)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (errField == 10'd0 && !busy && !resultValid));

  p_respond_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && !swReset) |=> resultValid);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !fragValid |=> !resultValid);

  p_single_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && fragStart && fragLast && !swReset) |=> !busy);

  p_open_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && fragStart && !fragLast && !swReset) |=> busy);

  p_overstart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && fragStart && busy && !swReset) |=> errField[7]);

  p_orphan_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fragValid && !fragStart && !busy && !swReset) |=> errField[8]);
endmodule

bind frag_seq_checker fsc_sva u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .swReset    (swReset),
  .fragValid  (fragValid),
  .fragStart  (fragStart),
  .fragLast   (fragLast),
  .busy       (busy),
  .errField   (errField),
  .resultValid(resultValid)
);

// File: tb/tb_frag_seq_checker.sv
module tb_frag_seq_checker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReset = 1'b0;
  logic        fragValid = 1'b0;
  logic        fragStart = 1'b0;
  logic        fragLast = 1'b0;
  logic        encEn = 1'b0;
  logic        macEn = 1'b0;
  logic [1:0]  cipherAlg = 2'd0;
  logic [15:0] encLen = '0;
  logic [15:0] srcWords = '0;
  logic [15:0] totalWords = '0;
  logic [8:0]  dstEncWritten = '0;
  logic [8:0]  dstEncLen = '0;
  logic [2:0]  dstMacWritten = '0;
  logic [2:0]  dstMacLen = '0;
  logic        encMacPending = 1'b0;
  logic [9:0]  intEn = '0;
  logic        busy;
  logic [9:0]  errField;
  logic        irq;
  logic        resultValid;
  logic [31:0] resultWord;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        mIn = 1'b0;
  logic [15:0] mAcc = '0;
  logic [15:0] mTot = '0;
  logic [9:0]  mErr = '0;
  logic [31:0] mWord = '0;

  frag_seq_checker dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] modelErr(input logic st, input logic ls, input logic [15:0] accN,
                                          input logic [15:0] tot);
    logic [9:0] e;
    logic mis;
    mis = (cipherAlg < 2) ? encLen[0] : (encLen[1:0] != 2'd0);
    e    = '0;
    e[0] = ls && (accN < tot);
    e[1] = (accN >= tot) && !ls;
    e[2] = ls && encMacPending;
    e[3] = ls && (dstMacWritten != dstMacLen);
    e[4] = dstEncWritten != dstEncLen;
    e[5] = st && (encLen == 16'd0);
    e[6] = st && !(encEn && macEn);
    e[7] = st && mIn;
    e[8] = !st && !mIn;
    e[9] = st && encEn && mis;
    return e;
  endfunction

  task automatic modelStep();
    logic [15:0] tot;
    logic [15:0] accN;
    logic orphan;
    tot    = fragStart ? totalWords : mTot;
    accN   = (fragStart ? 16'd0 : mAcc) + srcWords;
    orphan = !fragStart && !mIn;
    mErr   = mErr | modelErr(fragStart, fragLast, accN, tot);
    mWord  = '0;
    mWord[0] = fragLast;
    mWord[1] = accN >= tot;
    mWord[25:16] = mErr;
    mTot = tot;
    if (fragLast || orphan) mAcc = '0;
    else mAcc = accN;
    mIn = !fragLast && (fragStart || mIn);
  endtask

  task automatic doFrag(input string req);
    modelStep();
    fragValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fragValid = 1'b0;
    chk({req, " R10 strobe"}, {31'd0, resultValid}, 32'd1);
    chk({req, " R10 word"}, resultWord, mWord);
    chk({req, " errField"}, {22'd0, errField}, {22'd0, mErr});
    chk({req, " R9 irq"}, {31'd0, irq}, {31'd0, |(mErr & intEn)});
    chk({req, " R11 busy"}, {31'd0, busy}, {31'd0, mIn});
  endtask

  task automatic doSwReset();
    swReset = 1'b1;
    @(posedge clk);
    @(negedge clk);
    swReset = 1'b0;
    mErr = '0; mIn = 1'b0; mAcc = '0; mTot = '0;
    chk("R8 clear err", {22'd0, errField}, 32'd0);
    chk("R8 clear busy", {31'd0, busy}, 32'd0);
    chk("R8 clear strobe", {31'd0, resultValid}, 32'd0);
  endtask

  task automatic setGood(input logic st, input logic ls, input logic [15:0] src,
                         input logic [15:0] tot);
    fragStart = st; fragLast = ls; encEn = 1'b1; macEn = 1'b1;
    cipherAlg = 2'd3; encLen = 16'd8; srcWords = src; totalWords = tot;
    dstEncWritten = 9'd4; dstEncLen = 9'd4; dstMacWritten = 3'd3; dstMacLen = 3'd3;
    encMacPending = 1'b0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R12 reset busy", {31'd0, busy}, 32'd0);
    chk("R12 reset err", {22'd0, errField}, 32'd0);
    chk("R12 reset irq", {31'd0, irq}, 32'd0);
    chk("R12 reset strobe", {31'd0, resultValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    intEn = 10'h3FF;

    // Single fragment packet, clean
    setGood(1, 1, 16'd10, 16'd10);
    doFrag("R11 single");
    chk("R11 idle after single", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R10 no strobe idle", {31'd0, resultValid}, 32'd0);

    // Multi fragment clean, misleading totals on later fragments
    setGood(1, 0, 16'd4, 16'd10); doFrag("R11 open");
    chk("R11 busy open", {31'd0, busy}, 32'd1);
    setGood(0, 0, 16'd3, 16'd5); doFrag("R11 mid");
    setGood(0, 1, 16'd3, 16'd99); doFrag("R11 close");
    chk("R11 clean multi", {22'd0, errField}, 32'd0);

    // R1 short
    setGood(1, 0, 16'd4, 16'd10); doFrag("R1 open");
    setGood(0, 1, 16'd3, 16'd10); doFrag("R1 last");
    chk("R1 bit16", {31'd0, resultWord[16]}, 32'd1);
    doSwReset();

    // R2 reached without last
    setGood(1, 0, 16'd6, 16'd10); doFrag("R2 open");
    setGood(0, 0, 16'd4, 16'd1); doFrag("R2 reach");
    chk("R2 bit17", {31'd0, resultWord[17]}, 32'd1);
    setGood(0, 1, 16'd0, 16'd0); doFrag("R2 close");
    doSwReset();

    // R3 pending
    setGood(1, 1, 16'd5, 16'd5); encMacPending = 1'b1; doFrag("R3 pend");
    chk("R3 bit18", {31'd0, resultWord[18]}, 32'd1);
    doSwReset();

    // R4 counts
    setGood(1, 0, 16'd2, 16'd5); dstMacWritten = 3'd1; doFrag("R4 mac ignored mid");
    chk("R4 mac not on mid", {31'd0, errField[3]}, 32'd0);
    setGood(0, 1, 16'd3, 16'd5); dstMacWritten = 3'd5; doFrag("R4 mac last");
    chk("R4 bit19", {31'd0, errField[3]}, 32'd1);
    doSwReset();
    setGood(1, 1, 16'd2, 16'd2); dstEncWritten = 9'd7; doFrag("R4 enc");
    chk("R4 bit20", {31'd0, errField[4]}, 32'd1);
    doSwReset();

    // R5
    setGood(1, 1, 16'd2, 16'd2); encLen = 16'd0; doFrag("R5 zero");
    chk("R5 bit21", {31'd0, errField[5]}, 32'd1);
    doSwReset();
    setGood(1, 1, 16'd2, 16'd2); macEn = 1'b0; doFrag("R5 macoff");
    chk("R5 bit22", {31'd0, errField[6]}, 32'd1);
    doSwReset();

    // R6
    setGood(1, 0, 16'd2, 16'd9); doFrag("R6 open");
    setGood(1, 0, 16'd2, 16'd9); doFrag("R6 restart");
    chk("R6 bit23", {31'd0, errField[7]}, 32'd1);
    doSwReset();
    setGood(0, 1, 16'd2, 16'd2); doFrag("R6 orphan");
    chk("R6 bit24", {31'd0, errField[8]}, 32'd1);
    doSwReset();

    // R7
    setGood(1, 1, 16'd2, 16'd2); cipherAlg = 2'd0; encLen = 16'd6; doFrag("R7 des ok");
    chk("R7 des 6 ok", {31'd0, errField[9]}, 32'd0);
    setGood(1, 1, 16'd2, 16'd2); cipherAlg = 2'd1; encLen = 16'd3; doFrag("R7 3des bad");
    chk("R7 3des 3 bad", {31'd0, errField[9]}, 32'd1);
    doSwReset();
    setGood(1, 1, 16'd2, 16'd2); cipherAlg = 2'd2; encLen = 16'd6; doFrag("R7 seed bad");
    chk("R7 seed 6 bad", {31'd0, errField[9]}, 32'd1);
    doSwReset();

    // R8 sticky
    setGood(0, 1, 16'd1, 16'd1); doFrag("R8 make err");
    setGood(1, 1, 16'd4, 16'd4); doFrag("R8 good after");
    chk("R8 sticky bit24", {31'd0, errField[8]}, 32'd1);
    // R9 mask
    intEn = 10'h0FF;
    @(negedge clk);
    chk("R9 masked", {31'd0, irq}, 32'd0);
    intEn = 10'h100;
    @(negedge clk);
    chk("R9 enabled", {31'd0, irq}, 32'd1);
    // R8 swReset beats fragment
    setGood(0, 1, 16'd1, 16'd1); fragValid = 1'b1;
    doSwReset();
    fragValid = 1'b0;

    // Random phase
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 6 == 0) begin
        intEn = 10'($urandom);
        doSwReset();
      end
      fragStart = mIn ? ($urandom % 8 == 0) : ($urandom % 8 != 0);
      fragLast  = ($urandom % 3 == 0);
      encEn     = ($urandom % 10 != 0);
      macEn     = ($urandom % 10 != 0);
      cipherAlg = 2'($urandom);
      encLen    = ($urandom % 5 == 0) ? 16'($urandom % 7) : 16'(4 * (1 + $urandom % 4));
      srcWords  = 16'(1 + $urandom % 8);
      totalWords = 16'(srcWords * (1 + $urandom % 3));
      dstEncLen = 9'($urandom % 64);
      dstEncWritten = ($urandom % 10 == 0) ? 9'($urandom % 64) : dstEncLen;
      dstMacLen = 3'($urandom);
      dstMacWritten = ($urandom % 10 == 0) ? 3'($urandom) : dstMacLen;
      encMacPending = ($urandom % 12 == 0);
      doFrag("R1 R2 R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule